// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block consumes a stream of 32-bit configuration words, taking one word on each cycle where the valid strobe and its ready output are both high. After reset it is in a hunting state and discards everything until the synchronization word arrives. Once synchronized, it parses packet headers.

A type 1 header names a register and carries a short word count. A type 2 header carries a long word count and reuses the register named by the most recent type 1 header. Write payloads land in a small register bank. Writes to the frame-input register fill an internal frame array at an auto-incrementing frame address.

Read requests stream register contents, or a run of frame words, onto an output port. While that output is pending, input is held off. Words written to the command register drive a set of effects:

- desync returns the decoder to hunting;
- shutdown raises a halt flag;
- start clears the halt and readback flags;
- readback arms a readback flag;
- CRC reset clears the CRC register.

Malformed headers raise a sticky error flag and are dropped.

Top module: `cfg_stream_decoder`

## Requirements
- R1: While unsynchronized, every accepted word other than 0xAA995566 is discarded: no register, frame or output activity follows, and `synced` stays 0.
- R2: Accepting 0xAA995566 while unsynchronized sets `synced` to 1 from the next cycle.
- R3: While synchronized, the words 0xFFFFFFFF, 0x000000BB, 0x11220044 and 0xAA995566 are skipped, and the no-op header 0x20000000 is accepted. None of them changes a register or sets the error flag.
- R4: A type 1 header has bits [31:29]=001, opcode in bits [28:27] (00 no-op, 01 read, 10 write), register address in bits [17:13], and word count in bits [10:0]. A write with count N>0 stores the next N accepted words into that register, so the last one remains. A count of 0 takes no payload.
- R5: A read with count N>0 yields exactly N words on `out_data`, each with `out_valid` high, starting the cycle after the header is accepted. `in_ready` is 0 for those N cycles. A non-frame register returns its stored value.
- R6: A type 2 header has bits [31:29]=010, opcode in bits [28:27] and a count in bits [26:0]. It acts on the register named by the last type 1 header since synchronization. A type 1 read of address 3 with count 0, followed by a type 2 read of count N, returns N frame words starting at the frame address.
- R7: A write to address 1 loads the frame address. Each payload word written to address 2 is stored at the frame address, which then increments. Each frame word read from address 3 also increments it. The frame address wraps modulo the frame depth.
- R8: Writing 13 to the command register (address 4) clears `synced`. Later headers are ignored until the next synchronization word.
- R9: Command 11 sets `halted`. Command 4 sets `readback_armed`. Command 5 clears both.
- R10: Command 7 clears the CRC register (address 0).
- R11: A header is dropped, and `err_flag` set, when any of these holds:
  - bits [12:11] are nonzero;
  - address bits [26:18] are nonzero;
  - the type is neither 1 nor 2 (skip words excepted);
  - the opcode is 11;
  - it is a type 2 header with no type 1 header since synchronization.

  `err_flag` stays set until reset.
- R12: After reset: `synced`, `out_valid`, `err_flag`, `halted` and `readback_armed` are 0, `in_ready` is 1, and all registers and frame words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 32 | Input configuration word |
| in_ready | output | 1 | Block can take a word this cycle |
| out_valid | output | 1 | Read word present on `out_data` |
| out_data | output | 32 | Read word |
| synced | output | 1 | Decoder is synchronized |
| err_flag | output | 1 | Sticky malformed-header flag |
| halted | output | 1 | Shutdown command seen, no start since |
| readback_armed | output | 1 | Readback command seen, no start since |

## Verification
The hardest situation to reach from the ports is a type 2 header whose meaning depends on an earlier type 1 header. This matters most for the frame read, where the register, the frame address and the wrap of the frame array must all line up. The stimulus first loads a frame address two below the end of the array. It then writes four frame words through a zero-count type 1 write followed by a type 2 write, reloads the same address, and reads back through the zero-count read followed by a type 2 read. The words come back in order only if the inherited register, the address increment and the wrap are all correct. Each error cause is provoked from a fresh reset, so the sticky flag cannot hide one cause behind another.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  localparam int CNT_W = 27;

  localparam logic [31:0] W_SYNC      = 32'hAA99_5566;
  localparam logic [31:0] W_DUMMY     = 32'hFFFF_FFFF;
  localparam logic [31:0] W_BW_SYNC   = 32'h0000_00BB;
  localparam logic [31:0] W_BW_DETECT = 32'h1122_0044;

  localparam int REG_CRC  = 0;
  localparam int REG_FAR  = 1;
  localparam int REG_FDRI = 2;
  localparam int REG_FDRO = 3;
  localparam int REG_CMD  = 4;

  localparam logic [31:0] CMD_RCFG   = 32'd4;
  localparam logic [31:0] CMD_START  = 32'd5;
  localparam logic [31:0] CMD_RCRC   = 32'd7;
  localparam logic [31:0] CMD_SHUT   = 32'd11;
  localparam logic [31:0] CMD_DESYNC = 32'd13;

  typedef enum logic [1:0] {OP_NOP = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_BAD = 2'd3} op_e;
  typedef enum logic [1:0] {ST_HUNT, ST_HDR, ST_WPAY, ST_RD} pstate_e;

  function automatic logic [2:0] hdr_type(input logic [31:0] w);
    return w[31:29];
  endfunction

  function automatic op_e hdr_op(input logic [31:0] w);
    return op_e'(w[28:27]);
  endfunction

  function automatic logic [10:0] t1_count(input logic [31:0] w);
    return w[10:0];
  endfunction

  function automatic logic [CNT_W-1:0] t2_count(input logic [31:0] w);
    return w[CNT_W-1:0];
  endfunction

  // reserved gap bits, or address bits above the implemented bank
  function automatic logic t1_reserved_set(input logic [31:0] w, input int aw);
    logic [13:0] a;
    a = w[26:13];
    return (w[12:11] != 2'b00) || ((a >> aw) != 14'd0);
  endfunction

  function automatic logic is_skip(input logic [31:0] w);
    return (w == W_SYNC) || (w == W_DUMMY) || (w == W_BW_SYNC) || (w == W_BW_DETECT);
  endfunction

endpackage

// File: rtl/cfgdec_parser.sv
module cfgdec_parser
  import cfgdec_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic              synced,
  output logic              err_flag,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              rd_active,
  output logic [ADDR_W-1:0] rd_addr
);

  pstate_e           state_q;
  logic [CNT_W-1:0]  rem_q;
  logic [ADDR_W-1:0] cur_q, last_q;
  logic              have_t1_q, err_q;

  logic              accept;
  logic [2:0]        ty;
  op_e               op;
  logic              is_t1, is_t2, skip, bad;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] tgt;
  logic              hdr_ok, ev_hdr_err, go_wr, go_rd, ev_desync, ev_sync;

  assign in_ready = (state_q != ST_RD);
  assign accept   = in_valid && in_ready;

  assign ty    = hdr_type(in_data);
  assign op    = hdr_op(in_data);
  assign is_t1 = (ty == 3'd1);
  assign is_t2 = (ty == 3'd2);
  assign skip  = is_skip(in_data);
  assign bad   = !skip && (!(is_t1 || is_t2) || (op == OP_BAD) ||
                           (is_t1 && t1_reserved_set(in_data, ADDR_W)) ||
                           (is_t2 && !have_t1_q));
  assign cnt   = is_t1 ? CNT_W'(t1_count(in_data)) : t2_count(in_data);
  assign tgt   = is_t1 ? in_data[13 +: ADDR_W] : last_q;

  assign ev_sync    = (state_q == ST_HUNT) && accept && (in_data == W_SYNC);
  assign hdr_ok     = (state_q == ST_HDR) && accept && !skip && !bad;
  assign ev_hdr_err = (state_q == ST_HDR) && accept && bad;
  assign go_wr      = hdr_ok && (op == OP_WR) && (cnt != '0);
  assign go_rd      = hdr_ok && (op == OP_RD) && (cnt != '0);

  assign wr_en     = (state_q == ST_WPAY) && accept;
  assign wr_addr   = cur_q;
  assign wr_data   = in_data;
  assign ev_desync = wr_en && (cur_q == ADDR_W'(REG_CMD)) && (in_data == CMD_DESYNC);

  assign rd_active = (state_q == ST_RD);
  assign rd_addr   = cur_q;
  assign synced    = (state_q != ST_HUNT);
  assign err_flag  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_HUNT;
      rem_q     <= '0;
      cur_q     <= '0;
      last_q    <= '0;
      have_t1_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (ev_hdr_err) err_q <= 1'b1;
      unique case (state_q)
        ST_HUNT: if (ev_sync) begin
          state_q   <= ST_HDR;
          have_t1_q <= 1'b0;
        end
        ST_HDR: if (hdr_ok) begin
          if (is_t1) begin
            last_q    <= tgt;
            have_t1_q <= 1'b1;
          end
          if (go_wr || go_rd) begin
            state_q <= go_wr ? ST_WPAY : ST_RD;
            rem_q   <= cnt;
            cur_q   <= tgt;
          end
        end
        ST_WPAY: if (accept) begin
          rem_q <= rem_q - 1'b1;
          if (ev_desync)          state_q <= ST_HUNT;
          else if (rem_q == 'd1)  state_q <= ST_HDR;
        end
        ST_RD: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == 'd1) state_q <= ST_HDR;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  a_r2_sync_locks: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> synced);
  a_r8_desync_leaves_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desync |=> !synced);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  a_r5_read_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && rem_q > 'd1) |=> (rd_active && rem_q == $past(rem_q) - 1'b1));
  a_r4_payload_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ev_desync && rem_q > 'd1) |=> (state_q == ST_WPAY && rem_q == $past(rem_q) - 1'b1));
  a_r1_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (!wr_en && !rd_active));

endmodule

// File: rtl/cfgdec_regbank.sv
module cfgdec_regbank
  import cfgdec_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              halted,
  output logic              readback_armed
);

  localparam int NREGS = 2 ** ADDR_W;

  logic [DATA_W-1:0] regs [NREGS];
  logic              cmd_wr, ev_shut, ev_start, ev_rcfg, ev_rcrc;
  logic              halt_q, arm_q;

  assign cmd_wr   = wr_en && (wr_addr == ADDR_W'(REG_CMD));
  assign ev_shut  = cmd_wr && (wr_data == DATA_W'(CMD_SHUT));
  assign ev_start = cmd_wr && (wr_data == DATA_W'(CMD_START));
  assign ev_rcfg  = cmd_wr && (wr_data == DATA_W'(CMD_RCFG));
  assign ev_rcrc  = cmd_wr && (wr_data == DATA_W'(CMD_RCRC));

  assign rd_data        = regs[rd_addr];
  assign halted         = halt_q;
  assign readback_armed = arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      halt_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (wr_en) regs[wr_addr] <= wr_data;
      if (ev_rcrc) regs[REG_CRC] <= '0;
      if (ev_shut) halt_q <= 1'b1;
      if (ev_rcfg) arm_q  <= 1'b1;
      if (ev_start) begin
        halt_q <= 1'b0;
        arm_q  <= 1'b0;
      end
    end
  end

  a_r10_crc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rcrc |=> (regs[REG_CRC] == '0));
  a_r9_halt_on_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shut |=> halted);
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (!halted && !readback_armed));

endmodule

// File: rtl/cfgdec_frames.sv
module cfgdec_frames #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     addr_load,
  input  logic [$clog2(DEPTH)-1:0] addr_val,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     rd_step,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  ptr_q;

  assign rd_data = mem[ptr_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr_q <= '0;
    end else begin
      if (wr_en) mem[ptr_q] <= wr_data;
      if (addr_load)               ptr_q <= addr_val;
      else if (wr_en || rd_step)   ptr_q <= ptr_q + 1'b1;
    end
  end

  a_r7_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_step) && !addr_load) |=> (ptr_q == IDX_W'($past(ptr_q) + 1'b1)));
  a_r7_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (ptr_q == $past(addr_val)));

endmodule

// File: rtl/cfg_stream_decoder.sv
module cfg_stream_decoder
  import cfgdec_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int FRAME_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  output logic        synced,
  output logic        err_flag,
  output logic        halted,
  output logic        readback_armed
);

  localparam int IDX_W = $clog2(FRAME_DEPTH);

  logic              wr_en, rd_active;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [31:0]       wr_data, reg_rd, frame_rd;
  logic              frame_rd_sel, far_load, fdri_wr, fdro_step;

  cfgdec_parser #(.ADDR_W(ADDR_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .synced(synced), .err_flag(err_flag),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_active(rd_active), .rd_addr(rd_addr)
  );

  cfgdec_regbank #(.ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(reg_rd),
    .halted(halted), .readback_armed(readback_armed)
  );

  assign frame_rd_sel = (rd_addr == ADDR_W'(REG_FDRO));
  assign far_load     = wr_en && (wr_addr == ADDR_W'(REG_FAR));
  assign fdri_wr      = wr_en && (wr_addr == ADDR_W'(REG_FDRI));
  assign fdro_step    = rd_active && frame_rd_sel;

  cfgdec_frames #(.DATA_W(32), .DEPTH(FRAME_DEPTH)) u_frames (
    .clk(clk), .rst_n(rst_n), .addr_load(far_load),
    .addr_val(wr_data[IDX_W-1:0]), .wr_en(fdri_wr), .wr_data(wr_data),
    .rd_step(fdro_step), .rd_data(frame_rd)
  );

  assign out_valid = rd_active;
  assign out_data  = frame_rd_sel ? frame_rd : reg_rd;

  a_r5_input_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

endmodule

// File: tb/sim_cfg_stream_decoder.sv
module sim_cfg_stream_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, synced, err_flag, halted, readback_armed;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] got_q [$];

  always #5 clk = ~clk;

  cfg_stream_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .synced(synced), .err_flag(err_flag), .halted(halted),
    .readback_armed(readback_armed)
  );

  always @(negedge clk) if (out_valid) got_q.push_back(out_data);

  function automatic logic [31:0] t1(input logic [1:0] op, input int a, input int n);
    return {3'b001, op, 14'(a), 2'b00, 11'(n)};
  endfunction

  function automatic logic [31:0] t2(input logic [1:0] op, input int n);
    return {3'b010, op, 27'(n)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wr1(input int a, input logic [31:0] v);
    send(t1(2'b10, a, 1));
    send(v);
  endtask

  task automatic drain(input int n);
    repeat (n + 2) @(negedge clk);
    #1;
  endtask

  // single register read, returns first word; checks R5 handshake and count
  task automatic rd_reg(input int a, input int n, output logic [31:0] first);
    got_q.delete();
    send(t1(2'b01, a, n));
    chk("R5 in_ready low during read", {31'd0, in_ready}, 32'd0);
    drain(n);
    chk("R5 word count", got_q.size(), n);
    first = (got_q.size() > 0) ? got_q[0] : 32'hDEAD_BEEF;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    #1;
    chk("R12 synced", {31'd0, synced}, 0);
    chk("R12 out_valid", {31'd0, out_valid}, 0);
    chk("R12 in_ready", {31'd0, in_ready}, 1);
    chk("R12 err_flag", {31'd0, err_flag}, 0);
    chk("R12 halted", {31'd0, halted}, 0);
    chk("R12 readback_armed", {31'd0, readback_armed}, 0);
    send(32'hAA99_5566);
    rd_reg(9, 1, v);
    chk("R12 register zero", v, 0);
  endtask

  task automatic t_hunt();
    logic [31:0] v;
    do_reset();
    got_q.delete();
    send(t1(2'b10, 6, 1));
    send(32'h0000_1234);
    send(t1(2'b01, 6, 2));
    drain(2);
    chk("R1 unsynced stays low", {31'd0, synced}, 0);
    chk("R1 no output while hunting", got_q.size(), 0);
    chk("R1 no error while hunting", {31'd0, err_flag}, 0);
    send(32'hAA99_5566);
    chk("R2 synced after sync word", {31'd0, synced}, 1);
    rd_reg(6, 1, v);
    chk("R1 pre-sync write dropped", v, 0);
  endtask

  task automatic t_write_read();
    logic [31:0] v;
    send(t1(2'b10, 5, 3));
    send(32'hA); send(32'hB); send(32'hC);
    wr1(14, 32'h5A5A);
    send(t1(2'b10, 9, 0));
    wr1(10, 32'h77);
    rd_reg(9, 1, v);
    chk("R4 zero count takes no payload", v, 0);
    rd_reg(10, 1, v);
    chk("R4 header after zero count", v, 32'h77);
    rd_reg(5, 2, v);
    chk("R4 last payload kept", v, 32'hC);
    chk("R5 repeated word", (got_q.size() > 1) ? got_q[1] : 0, 32'hC);
    rd_reg(14, 1, v);
    chk("R5 read register", v, 32'h5A5A);
  endtask

  task automatic t_skip();
    logic [31:0] v;
    send(32'hFFFF_FFFF);
    send(32'h0000_00BB);
    send(32'h1122_0044);
    send(32'hAA99_5566);
    send(32'h2000_0000);
    chk("R3 no error on skip words", {31'd0, err_flag}, 0);
    chk("R3 still synced", {31'd0, synced}, 1);
    rd_reg(10, 1, v);
    chk("R3 register untouched", v, 32'h77);
  endtask

  task automatic t_frames();
    logic [31:0] v;
    wr1(1, 32'd62);
    send(t1(2'b10, 2, 0));
    send(t2(2'b10, 4));
    for (int i = 0; i < 4; i++) send(32'hF000_0000 + i);
    wr1(1, 32'd62);
    send(t1(2'b01, 3, 0));
    got_q.delete();
    send(t2(2'b01, 4));
    chk("R6 in_ready low during frame read", {31'd0, in_ready}, 0);
    drain(4);
    chk("R6 frame word count", got_q.size(), 4);
    for (int i = 0; i < 4; i++)
      chk("R7 frame word with wrap", (got_q.size() > i) ? got_q[i] : 0, 32'hF000_0000 + i);
    wr1(1, 32'd0);
    rd_reg(3, 1, v);
    chk("R7 wrapped slot zero", v, 32'hF000_0002);
    send(t1(2'b10, 6, 0));
    send(t2(2'b10, 2));
    send(32'h1111); send(32'h2222);
    rd_reg(6, 1, v);
    chk("R6 type 2 inherits register", v, 32'h2222);
  endtask

  task automatic t_cmds();
    logic [31:0] v;
    wr1(4, 32'd11);
    chk("R9 shutdown halts", {31'd0, halted}, 1);
    wr1(4, 32'd4);
    chk("R9 readback arms", {31'd0, readback_armed}, 1);
    wr1(4, 32'd5);
    chk("R9 start clears halt", {31'd0, halted}, 0);
    chk("R9 start clears arm", {31'd0, readback_armed}, 0);
    wr1(0, 32'hDEAD);
    rd_reg(0, 1, v);
    chk("R10 crc written", v, 32'hDEAD);
    wr1(4, 32'd7);
    rd_reg(0, 1, v);
    chk("R10 crc reset", v, 0);
  endtask

  task automatic t_desync();
    logic [31:0] v;
    wr1(6, 32'h55);
    wr1(4, 32'd13);
    chk("R8 desync drops sync", {31'd0, synced}, 0);
    wr1(6, 32'h99);
    send(32'hAA99_5566);
    rd_reg(6, 1, v);
    chk("R8 ignored after desync", v, 32'h55);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    do_reset();
    send(32'hAA99_5566);
    send(t1(2'b10, 6, 1) | 32'h0000_0800);
    send(32'h2000_0000);
    chk("R11 reserved gap bits", {31'd0, err_flag}, 1);
    rd_reg(6, 1, v);
    chk("R11 bad header dropped", v, 0);
    wr1(6, 32'h3);
    chk("R11 error sticky", {31'd0, err_flag}, 1);
    do_reset();
    send(32'hAA99_5566);
    send(t2(2'b10, 1));
    chk("R11 type 2 without type 1", {31'd0, err_flag}, 1);
    do_reset();
    send(32'hAA99_5566);
    send(32'h6000_0000);
    chk("R11 bad type", {31'd0, err_flag}, 1);
    do_reset();
    send(32'hAA99_5566);
    send(t1(2'b11, 6, 1));
    chk("R11 reserved opcode", {31'd0, err_flag}, 1);
    do_reset();
    send(32'hAA99_5566);
    send(t1(2'b10, 32 + 6, 1));
    chk("R11 high address bits", {31'd0, err_flag}, 1);
  endtask

  initial begin
    t_reset();
    t_hunt();
    t_write_read();
    t_skip();
    t_frames();
    t_cmds();
    t_desync();
    t_errors();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule